// File: doc/BRIEF.md
# DMA Descriptor Condition Evaluator

This block sits beside a descriptor-driven DMA sequencer and settles three per-descriptor choices: whether to signal an interrupt, whether to jump to the descriptor's branch target instead of advancing to the next slot, and whether to hold the descriptor in a stalled state. Each choice comes from its own 2-bit mode field in the command word. A mode either ignores the device outright (never, always) or acts on a condition. The condition is a masked compare between the low nibble of the device status byte and a compare value. The mask and compare value are both held in a select register dedicated to that choice.

The three decisions are combinational, so the sequencer reads them in the same cycle that it presents the command word, the select registers and the status. The interrupt decision is also registered into a single-cycle strobe. The strobe fires only for cycles in which the sequencer raises the evaluate-enable input. All inputs are plain control levels with no handshake. The sequencer owns the timing, holding the inputs stable for as long as it needs the answers.

Top module: `dma_cond_eval`

## Requirements
- R1: The interrupt mode is `cmd_word[5:4]`, the branch mode `cmd_word[3:2]` and the stall mode `cmd_word[1:0]`; all other command bits have no effect on any output.
- R2: Mode 0 (never) keeps its decision low whatever the select register and status hold.
- R3: Mode 3 (always) drives its decision high whatever the select register and status hold.
- R4: Mode 1 drives its decision high exactly when its condition is true.
- R5: Mode 2 drives its decision high exactly when its condition is false.
- R6: A condition is true when `(dev_status[3:0] & sel[19:16]) == (sel[3:0] & sel[19:16])`; status bits 7:4 and select bits outside 19:16 and 3:0 are ignored.
- R7: A select mask of zero makes the condition true, so mode 1 always acts and mode 2 never acts.
- R8: The interrupt uses `irq_sel`, the branch uses `br_sel` and the stall uses `wait_sel`; no decision reads another decision's select register.
- R9: `seq_adv` is high exactly when `br_take` is low.
- R10: `irq_pulse` is high for one cycle after a clock edge at which `eval_en` and `irq_act` were both high, and low after every other edge.
- R11: While `rst_n` is low, `irq_pulse` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| eval_en | input | 1 | Evaluate this cycle; gates the interrupt strobe |
| cmd_word | input | 16 | Descriptor command word holding the three mode fields |
| irq_sel | input | 32 | Interrupt select register: mask in 19:16, value in 3:0 |
| br_sel | input | 32 | Branch select register: mask in 19:16, value in 3:0 |
| wait_sel | input | 32 | Stall select register: mask in 19:16, value in 3:0 |
| dev_status | input | 8 | Device status byte |
| irq_act | output | 1 | Interrupt decision (combinational) |
| br_take | output | 1 | Take the branch target |
| seq_adv | output | 1 | Advance to the next sequential descriptor |
| wait_stall | output | 1 | Hold the current descriptor |
| irq_pulse | output | 1 | Registered one-cycle interrupt strobe |

## Verification
The bench builds the block with its default parameters: a 16-bit command word, 32-bit select registers, an 8-bit status and a 4-bit compare field with the mask at bit 16. At this size, status bits above the compare nibble and select bits outside both fields can be filled with noise. A model that reads too wide a slice, or the wrong one, then shows up as a mismatch. Directed vectors reach each mode value, the zero-mask case and the crossing of select registers between decisions, and several hundred random vectors cover the mode and compare combinations.

// File: rtl/dce_pkg.sv
package dce_pkg;

  typedef enum logic [1:0] {
    ACT_NEVER    = 2'd0,
    ACT_IF_TRUE  = 2'd1,
    ACT_IF_FALSE = 2'd2,
    ACT_ALWAYS   = 2'd3
  } act_mode_e;

  localparam int NUM_DEC  = 3;
  localparam int DEC_IRQ  = 0;
  localparam int DEC_BR   = 1;
  localparam int DEC_WAIT = 2;
  localparam int MODE_W   = 2;

  // Bit position of each decision's mode field within the command word.
  function automatic int mode_lsb(input int dec);
    return (NUM_DEC - 1 - dec) * MODE_W;
  endfunction

endpackage

// File: rtl/dce_sel_match.sv
module dce_sel_match #(
  parameter int SEL_W    = 32,
  parameter int STAT_W   = 8,
  parameter int COND_W   = 4,
  parameter int MASK_LSB = 16
) (
  input  logic [SEL_W-1:0]  sel,
  input  logic [STAT_W-1:0] status,
  output logic              hit
);
  localparam int VAL_LSB = 0;

  logic [COND_W-1:0] mask;
  logic [COND_W-1:0] want;
  logic [COND_W-1:0] seen;

  always_comb begin
    mask = sel[MASK_LSB +: COND_W];
    want = sel[VAL_LSB +: COND_W] & mask;
    seen = status[COND_W-1:0] & mask;
    hit  = (seen == want);
  end
endmodule

// File: rtl/dce_mode_act.sv
module dce_mode_act
  import dce_pkg::*;
(
  input  act_mode_e mode,
  input  logic      cond,
  output logic      act
);
  always_comb begin
    unique case (mode)
      ACT_NEVER:    act = 1'b0;
      ACT_IF_TRUE:  act = cond;
      ACT_IF_FALSE: act = ~cond;
      ACT_ALWAYS:   act = 1'b1;
      default:      act = 1'b0;
    endcase
  end
endmodule

// File: rtl/dma_cond_eval.sv
module dma_cond_eval
  import dce_pkg::*;
#(
  parameter int CMD_W    = 16,
  parameter int SEL_W    = 32,
  parameter int STAT_W   = 8,
  parameter int COND_W   = 4,
  parameter int MASK_LSB = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              eval_en,
  input  logic [CMD_W-1:0]  cmd_word,
  input  logic [SEL_W-1:0]  irq_sel,
  input  logic [SEL_W-1:0]  br_sel,
  input  logic [SEL_W-1:0]  wait_sel,
  input  logic [STAT_W-1:0] dev_status,
  output logic              irq_act,
  output logic              br_take,
  output logic              seq_adv,
  output logic              wait_stall,
  output logic              irq_pulse
);
  localparam int IRQ_LSB  = mode_lsb(DEC_IRQ);
  localparam int BR_LSB   = mode_lsb(DEC_BR);
  localparam int WAIT_LSB = mode_lsb(DEC_WAIT);

  logic [SEL_W-1:0] sel_arr [NUM_DEC];
  logic [NUM_DEC-1:0] cond_hit;
  logic [NUM_DEC-1:0] dec_act;

  always_comb begin
    sel_arr[DEC_IRQ]  = irq_sel;
    sel_arr[DEC_BR]   = br_sel;
    sel_arr[DEC_WAIT] = wait_sel;
  end

  for (genvar g = 0; g < NUM_DEC; g++) begin : g_dec
    act_mode_e mode;
    assign mode = act_mode_e'(cmd_word[mode_lsb(g) +: MODE_W]);

    dce_sel_match #(
      .SEL_W    (SEL_W),
      .STAT_W   (STAT_W),
      .COND_W   (COND_W),
      .MASK_LSB (MASK_LSB)
    ) u_match (
      .sel    (sel_arr[g]),
      .status (dev_status),
      .hit    (cond_hit[g])
    );

    dce_mode_act u_act (
      .mode (mode),
      .cond (cond_hit[g]),
      .act  (dec_act[g])
    );
  end

  assign irq_act    = dec_act[DEC_IRQ];
  assign br_take    = dec_act[DEC_BR];
  assign seq_adv    = ~dec_act[DEC_BR];
  assign wait_stall = dec_act[DEC_WAIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_pulse <= 1'b0;
    else        irq_pulse <= eval_en & irq_act;
  end

  AST_NEVER_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_word[IRQ_LSB +: MODE_W] == 2'd0) |-> !irq_act); // R2
  AST_ALWAYS_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_word[WAIT_LSB +: MODE_W] == 2'd3) |-> wait_stall); // R3
  AST_ZERO_MASK_TRUE: assert property (@(posedge clk) disable iff (!rst_n)
    ((br_sel[MASK_LSB +: COND_W] == '0) && (cmd_word[BR_LSB +: MODE_W] == 2'd1))
      |-> br_take); // R7
  AST_ADV_WHEN_NO_BRANCH: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_word[BR_LSB +: MODE_W] == 2'd0) |-> (seq_adv && !br_take)); // R9
  AST_PULSE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> $past(eval_en)); // R10
  AST_PULSE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_en && irq_act) |=> irq_pulse); // R10
endmodule

// File: tb/test_dma_cond_eval.sv
module test_dma_cond_eval;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        eval_en = 1'b0;
  logic [15:0] cmd_word = '0;
  logic [31:0] irq_sel = '0, br_sel = '0, wait_sel = '0;
  logic [7:0]  dev_status = '0;
  logic        irq_act, br_take, seq_adv, wait_stall, irq_pulse;

  int checks = 0;
  int fails  = 0;

  typedef struct {
    logic  irq, br, adv, stl, pls;
    string tag;
  } exp_t;
  exp_t sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_cond_eval i_dma_cond_eval (
    .clk(clk), .rst_n(rst_n), .eval_en(eval_en), .cmd_word(cmd_word),
    .irq_sel(irq_sel), .br_sel(br_sel), .wait_sel(wait_sel),
    .dev_status(dev_status), .irq_act(irq_act), .br_take(br_take),
    .seq_adv(seq_adv), .wait_stall(wait_stall), .irq_pulse(irq_pulse)
  );

  // Reference model written from R4-R7.
  function automatic logic m_cond(input logic [31:0] sel, input logic [7:0] st);
    return ((st[3:0] & sel[19:16]) == (sel[3:0] & sel[19:16]));
  endfunction

  function automatic logic m_act(input logic [1:0] mode, input logic c);
    case (mode)
      2'd0:    return 1'b0;
      2'd1:    return c;
      2'd2:    return ~c;
      default: return 1'b1;
    endcase
  endfunction

  task automatic chk(input string what, input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  task automatic drive(input logic [15:0] cmd, input logic [31:0] isel,
                       input logic [31:0] bsel, input logic [31:0] wsel,
                       input logic [7:0] st, input logic en, input string tag);
    exp_t e;
    @(negedge clk);
    cmd_word = cmd; irq_sel = isel; br_sel = bsel; wait_sel = wsel;
    dev_status = st; eval_en = en;
    e.irq = m_act(cmd[5:4], m_cond(isel, st));
    e.br  = m_act(cmd[3:2], m_cond(bsel, st));
    e.adv = ~e.br;
    e.stl = m_act(cmd[1:0], m_cond(wsel, st));
    e.pls = en & e.irq;
    e.tag = tag;
    sb_q.push_back(e);
  endtask

  // Monitor: one time unit after each edge, compares against the oldest item.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (rst_n && sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        chk("irq_act",    e.tag, irq_act,    e.irq);
        chk("br_take",    e.tag, br_take,    e.br);
        chk("seq_adv",    "R9",  seq_adv,    e.adv);
        chk("wait_stall", e.tag, wait_stall, e.stl);
        chk("irq_pulse",  "R10", irq_pulse,  e.pls);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    // R11: interrupt always requested with eval_en high, still held in reset.
    cmd_word = 16'h0030; eval_en = 1'b1;
    repeat (3) begin
      @(posedge clk); #1;
      chk("irq_pulse in reset", "R11", irq_pulse, 1'b0);
    end
    @(negedge clk); eval_en = 1'b0;
    @(negedge clk); rst_n = 1'b1;

    // R1: each field alone, junk in the unused command bits.
    drive(16'h0030, 32'h0, 32'h0, 32'h0, 8'h00, 1'b1, "R1");
    drive(16'h000C, 32'h0, 32'h0, 32'h0, 8'h00, 1'b1, "R1");
    drive(16'h0003, 32'h0, 32'h0, 32'h0, 8'h00, 1'b1, "R1");
    drive(16'hFFC0, 32'h0, 32'h0, 32'h0, 8'hFF, 1'b1, "R1");
    // R2 / R3: never and always with noisy selects and status.
    drive(16'h0000, 32'hFFFF_FFFF, 32'h000F_0000, 32'h5A5A_A5A5, 8'h3C, 1'b1, "R2");
    drive(16'h003F, 32'h000F_000A, 32'h000F_0005, 32'h000F_0003, 8'hC0, 1'b1, "R3");
    // R4 / R5 / R6: full mask, status high nibble noise.
    drive(16'h0015, 32'hFFFF_FFF5, 32'h000F_0005, 32'h7FFF_8005, 8'hA5, 1'b1, "R4");
    drive(16'h0015, 32'h000F_0005, 32'h000F_0005, 32'h000F_0005, 8'h54, 1'b1, "R4");
    drive(16'h002A, 32'h000F_0005, 32'h000F_0005, 32'h000F_0005, 8'h54, 1'b1, "R5");
    drive(16'h002A, 32'h000F_0005, 32'h000F_0005, 32'h000F_0005, 8'hF5, 1'b1, "R5");
    // R6: partial mask 0x3 compares only bits 1:0.
    drive(16'h0015, 32'h0003_000D, 32'h0003_000D, 32'h0003_000D, 8'h01, 1'b1, "R6");
    drive(16'h0015, 32'h0003_000D, 32'h0003_000D, 32'h0003_000D, 8'h02, 1'b1, "R6");
    // R7: zero mask, value and status differ.
    drive(16'h0015, 32'hFFF0_FFFF, 32'h0000_000A, 32'h0000_0007, 8'h00, 1'b1, "R7");
    drive(16'h002A, 32'hFFF0_FFFF, 32'h0000_000A, 32'h0000_0007, 8'h00, 1'b1, "R7");
    // R8: only the branch select matches the status.
    drive(16'h0015, 32'h000F_0001, 32'h000F_0006, 32'h000F_0009, 8'h06, 1'b1, "R8");
    drive(16'h0015, 32'h000F_0006, 32'h000F_0001, 32'h000F_0001, 8'h06, 1'b1, "R8");
    // R10: interrupt active but evaluation disabled, then back-to-back enabled.
    drive(16'h0030, 32'h0, 32'h0, 32'h0, 8'h00, 1'b0, "R10");
    drive(16'h0030, 32'h0, 32'h0, 32'h0, 8'h00, 1'b1, "R10");
    drive(16'h0030, 32'h0, 32'h0, 32'h0, 8'h00, 1'b1, "R10");
    drive(16'h0000, 32'h0, 32'h0, 32'h0, 8'h00, 1'b1, "R10");
    // Random sweep over modes, masks and status.
    for (int i = 0; i < 400; i++) begin
      drive(16'($urandom), $urandom, $urandom, $urandom, 8'($urandom),
            1'($urandom), "R6");
    end
    @(negedge clk); eval_en = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule